// File: doc/BRIEF.md
# Dual-Format Host Bus Register Front End

This block sits between an 8-bit parallel host processor bus and a sixteen-entry register file. It accepts host cycles in either of two address styles, chosen once per reset by a strap input. The first style puts the address and the data on one shared bus, with an address strobe marking the address phase. The second style uses a separate 4-bit address bus. A format input selects the strobe convention. The first convention uses separate active-low read and write strobes. The second uses one active-high data strobe together with a direction line. Every host input passes through a two-stage synchroniser into the core clock domain.

The front end holds the latched register address. For each qualified host read it issues a one-cycle read pulse, captures the register file's read data and drives it onto the bus. For each qualified host write it issues a one-cycle write pulse, with the data the host held at the end of the strobe. It also drives an active-low interrupt. The interrupt goes low when the serial engine reports a finished transfer, is gated by an enable bit, and is released when the host reads the status register.

The control FSM has four states. ST_BOOT is entered from reset and samples the strap. ST_IDLE waits for an access. ST_READ lasts while a read strobe is active. ST_WRITE lasts while a write strobe is active. Its transitions are:
- ST_BOOT→ST_IDLE, always, after one cycle.
- ST_IDLE→ST_READ when a qualified read becomes active. Read wins if both a read and a write are active.
- ST_IDLE→ST_WRITE when a qualified write becomes active.
- ST_READ→ST_IDLE when the read ends.
- ST_WRITE→ST_IDLE when the write ends. The write pulse is issued on this transition.

Top module: `hbus_front`

## Requirements
- R1: The mode is fixed by `mux_strap_n` as sampled in the first cycle after reset release. 0 selects the shared address/data style and 1 selects the separate-address style. Later changes of `mux_strap_n` have no effect until the next reset.
- R2: In shared mode, while `as_strb` is high, the register address is taken from `data_in[3:0]`. `data_in[7:4]` and `addr_in` are ignored for addressing.
- R3: With `fmt_sep`=1, `rd_ds` low marks a read and `wr_rw` low marks a write. Both are active low.
- R4: With `fmt_sep`=0, `rd_ds` high is the data strobe. During it, `wr_rw`=1 marks a read and `wr_rw`=0 marks a write.
- R5: No read or write pulse is produced for strobe activity while `ce_n` is high.
- R6: Each host write gives exactly one single-cycle `wr_pulse`, after the strobe's trailing edge. The pulse carries the latched address and the data held on the bus at the end of the strobe.
- R7: Each host read gives exactly one single-cycle `rd_pulse` at the strobe's leading edge. `rd_pulse` and `wr_pulse` are never high in the same cycle. `data_out` then returns `rd_data` for the addressed register.
- R8: `data_oe` is high only during a qualified read access, and is low otherwise, including the whole of a write.
- R9: In separate-address mode with `irq_en`=1, a `xfer_done` pulse drives `irq_n` low the next cycle. With `irq_en`=0, `irq_n` stays high while the request remains pending.
- R10: A host read of register address 0xE clears the pending interrupt, so `irq_n` is high the cycle after that `rd_pulse`. A `xfer_done` in the same cycle takes priority over the clear.
- R11: In shared mode, `irq_n` stays high whatever `xfer_done` and `irq_en` do.
- R12: While `rst_n` is low: `irq_n`=1, `data_oe`=0, `rd_pulse`=0 and `wr_pulse`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, same state as power-on |
| mux_strap_n | input | 1 | Mode strap: 0 = shared address/data, 1 = separate address |
| fmt_sep | input | 1 | Strobe convention: 1 = separate read/write strobes, 0 = data strobe plus direction |
| ce_n | input | 1 | Active-low chip enable |
| as_strb | input | 1 | Address strobe, active high (shared mode) |
| rd_ds | input | 1 | Read strobe (active low) or data strobe (active high) |
| wr_rw | input | 1 | Write strobe (active low) or direction (1 = read) |
| addr_in | input | 4 | Address bus (separate-address mode) |
| data_in | input | 8 | Host bus input data |
| data_out | output | 8 | Host bus read data |
| data_oe | output | 1 | Bus driver enable for `data_out` |
| reg_addr | output | 4 | Latched register address |
| wr_data | output | 8 | Write data toward the register file |
| wr_pulse | output | 1 | One-cycle register write pulse |
| rd_pulse | output | 1 | One-cycle register read pulse |
| rd_data | input | 8 | Read data from the register file |
| irq_en | input | 1 | Interrupt enable bit |
| xfer_done | input | 1 | One-cycle pulse: serial transfer completed |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that `xfer_done` is a single-cycle pulse and that `irq_en` is held steady around the cycle in which a completion is signalled. They also assume that the host holds address and data steady for at least three core cycles around each strobe edge, because every host input passes through the same two-stage delay. The stimulus changes host signals only on falling clock edges. It keeps setup and hold windows of several cycles, keeps the strap steady across each reset release, and holds `ce_n` low before a strobe starts and until after it ends.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } bus_state_t;

    localparam int HB_DATA_W = 8;
    localparam int HB_ADDR_W = 4;

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg[i] <= RST_VAL;
            end
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/hbus_strobe_dec.sv
module hbus_strobe_dec (
    input  logic ce_n_s,
    input  logic rd_ds_s,
    input  logic wr_rw_s,
    input  logic sep_s,
    output logic rd_act,
    output logic wr_act
);

    logic sep_rd, sep_wr, cmb_rd, cmb_wr;

    always_comb begin
        // separate active-low strobes, read has priority
        sep_rd = ~rd_ds_s;
        sep_wr = ~wr_rw_s & rd_ds_s;
        // active-high data strobe with direction line
        cmb_rd = rd_ds_s & wr_rw_s;
        cmb_wr = rd_ds_s & ~wr_rw_s;
        if (sep_s) begin
            rd_act = ~ce_n_s & sep_rd;
            wr_act = ~ce_n_s & sep_wr;
        end else begin
            rd_act = ~ce_n_s & cmb_rd;
            wr_act = ~ce_n_s & cmb_wr;
        end
    end

endmodule

// File: rtl/hbus_ctrl.sv
module hbus_ctrl
    import hbus_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mux_strap_n,
    input  logic              as_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    input  logic              rd_act,
    input  logic              wr_act,
    input  logic [DATA_W-1:0] rd_data,
    output logic              mux_mode,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_pulse,
    output logic              rd_pulse,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);

    bus_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:  state_d = ST_IDLE;
            ST_IDLE: begin
                if (rd_act)      state_d = ST_READ;
                else if (wr_act) state_d = ST_WRITE;
            end
            ST_READ:  if (!rd_act) state_d = ST_IDLE;
            ST_WRITE: if (!wr_act) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mux_mode <= 1'b0;
            reg_addr <= '0;
            wr_data  <= '0;
            wr_pulse <= 1'b0;
            rd_pulse <= 1'b0;
            data_out <= '0;
            data_oe  <= 1'b0;
        end else begin
            rd_pulse <= (state_q == ST_IDLE) && (state_d == ST_READ);
            wr_pulse <= (state_q == ST_WRITE) && (state_d == ST_IDLE);
            data_oe  <= (state_d == ST_READ);
            if (state_q == ST_BOOT) begin
                mux_mode <= ~mux_strap_n;
            end
            if (state_q == ST_IDLE) begin
                if (mux_mode && as_s) begin
                    reg_addr <= data_s[ADDR_W-1:0];
                end else if (!mux_mode && (rd_act || wr_act)) begin
                    reg_addr <= addr_s;
                end
            end
            if (wr_act && (state_q == ST_IDLE || state_q == ST_WRITE) && !rd_act) begin
                wr_data <= data_s;
            end
            if (rd_pulse) begin
                data_out <= rd_data;
            end
        end
    end

endmodule

// File: rtl/hbus_irq.sv
module hbus_irq #(
    parameter int          ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 4'hE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mux_mode,
    input  logic              irq_en,
    input  logic              xfer_done,
    input  logic              rd_pulse,
    input  logic [ADDR_W-1:0] reg_addr,
    output logic              irq_n
);

    logic pending_q;
    logic status_rd;

    assign status_rd = rd_pulse && (reg_addr == STATUS_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pending_q <= 1'b0;
        else if (xfer_done)  pending_q <= 1'b1;
        else if (status_rd)  pending_q <= 1'b0;
    end

    assign irq_n = ~(pending_q & irq_en & ~mux_mode);

endmodule

// File: rtl/hbus_front.sv
module hbus_front
    import hbus_pkg::*;
#(
    parameter int                  DATA_W      = HB_DATA_W,
    parameter int                  ADDR_W      = HB_ADDR_W,
    parameter int                  SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0]   STATUS_ADDR = 4'hE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mux_strap_n,
    input  logic              fmt_sep,
    input  logic              ce_n,
    input  logic              as_strb,
    input  logic              rd_ds,
    input  logic              wr_rw,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_pulse,
    output logic              rd_pulse,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              irq_en,
    input  logic              xfer_done,
    output logic              irq_n
);

    localparam int SYNC_W = 5 + ADDR_W + DATA_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, 1'b0, 1'b1, 1'b1, 1'b1,
                                              {ADDR_W{1'b0}}, {DATA_W{1'b0}}};

    logic              ce_n_s, as_s, rd_ds_s, wr_rw_s, sep_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic              rd_act, wr_act;
    logic              mux_mode;

    hbus_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ce_n, as_strb, rd_ds, wr_rw, fmt_sep, addr_in, data_in}),
        .q     ({ce_n_s, as_s, rd_ds_s, wr_rw_s, sep_s, addr_s, data_s})
    );

    hbus_strobe_dec dec_i (
        .ce_n_s  (ce_n_s),
        .rd_ds_s (rd_ds_s),
        .wr_rw_s (wr_rw_s),
        .sep_s   (sep_s),
        .rd_act  (rd_act),
        .wr_act  (wr_act)
    );

    hbus_ctrl #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mux_strap_n (mux_strap_n),
        .as_s        (as_s),
        .addr_s      (addr_s),
        .data_s      (data_s),
        .rd_act      (rd_act),
        .wr_act      (wr_act),
        .rd_data     (rd_data),
        .mux_mode    (mux_mode),
        .reg_addr    (reg_addr),
        .wr_data     (wr_data),
        .wr_pulse    (wr_pulse),
        .rd_pulse    (rd_pulse),
        .data_out    (data_out),
        .data_oe     (data_oe)
    );

    hbus_irq #(
        .ADDR_W      (ADDR_W),
        .STATUS_ADDR (STATUS_ADDR)
    ) irq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mux_mode  (mux_mode),
        .irq_en    (irq_en),
        .xfer_done (xfer_done),
        .rd_pulse  (rd_pulse),
        .reg_addr  (reg_addr),
        .irq_n     (irq_n)
    );

endmodule

// File: rtl/hbus_front_chk.sv
module hbus_front_chk #(
    parameter int                ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 4'hE
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_pulse,
    input logic              rd_pulse,
    input logic              data_oe,
    input logic              irq_n,
    input logic              irq_en,
    input logic              xfer_done,
    input logic              mux_mode,
    input logic [ADDR_W-1:0] reg_addr
);

    // R6
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    // R7
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pulse |=> !rd_pulse);

    // R7
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_pulse && wr_pulse));

    // R8
    oe_off_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> !data_oe);

    // R9
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && irq_en && !mux_mode) |=> (!irq_n || !irq_en));

    // R10
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pulse && reg_addr == STATUS_ADDR && !xfer_done) |=> irq_n);

    // R11
    irq_mux_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mux_mode |-> irq_n);

endmodule

bind hbus_front hbus_front_chk #(
    .ADDR_W      (ADDR_W),
    .STATUS_ADDR (STATUS_ADDR)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_pulse  (wr_pulse),
    .rd_pulse  (rd_pulse),
    .data_oe   (data_oe),
    .irq_n     (irq_n),
    .irq_en    (irq_en),
    .xfer_done (xfer_done),
    .mux_mode  (mux_mode),
    .reg_addr  (reg_addr)
);

// File: tb/hbus_front_tb.sv
module hbus_front_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mux_strap_n = 1'b1;
    logic       fmt_sep = 1'b1;
    logic       ce_n = 1'b1;
    logic       as_strb = 1'b0;
    logic       rd_ds = 1'b1;
    logic       wr_rw = 1'b1;
    logic [3:0] addr_in = '0;
    logic [7:0] data_in = '0;
    logic [7:0] data_out;
    logic       data_oe;
    logic [3:0] reg_addr;
    logic [7:0] wr_data;
    logic       wr_pulse;
    logic       rd_pulse;
    logic [7:0] rd_data;
    logic       irq_en = 1'b0;
    logic       xfer_done = 1'b0;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit mux_m = 1'b0;

    logic [7:0]  regs    [16];
    logic [7:0]  exp_mem [16];
    logic [11:0] wr_q[$];
    logic [3:0]  rd_q[$];

    always #2 clk = ~clk;

    hbus_front dut_i (
        .clk(clk), .rst_n(rst_n), .mux_strap_n(mux_strap_n), .fmt_sep(fmt_sep),
        .ce_n(ce_n), .as_strb(as_strb), .rd_ds(rd_ds), .wr_rw(wr_rw),
        .addr_in(addr_in), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .reg_addr(reg_addr), .wr_data(wr_data), .wr_pulse(wr_pulse), .rd_pulse(rd_pulse),
        .rd_data(rd_data), .irq_en(irq_en), .xfer_done(xfer_done), .irq_n(irq_n)
    );

    assign rd_data = regs[reg_addr];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: scoreboard pops expected items as pulses appear
    always @(negedge clk) begin
        if (rst_n && wr_pulse) begin
            if (wr_q.size() == 0) begin
                chk(1'b0, "R5/R6 unexpected wr_pulse", {reg_addr, wr_data}, 0);
            end else begin
                logic [11:0] e;
                e = wr_q.pop_front();
                chk({reg_addr, wr_data} == e, "R6 write addr/data", {reg_addr, wr_data}, e);
            end
            regs[reg_addr] <= wr_data;
        end
        if (rst_n && rd_pulse) begin
            if (rd_q.size() == 0) begin
                chk(1'b0, "R5/R7 unexpected rd_pulse", reg_addr, 0);
            end else begin
                logic [3:0] ea;
                ea = rd_q.pop_front();
                chk(reg_addr == ea, "R7 read addr", reg_addr, ea);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic addr_phase(input logic [3:0] a);
        if (mux_m) begin
            addr_in = ~a;
            data_in = {4'hA, a};
            as_strb = 1'b1;
            cyc(4);
            as_strb = 1'b0;
            cyc(1);
        end else begin
            addr_in = a;
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d, input bit sel);
        addr_phase(a);
        data_in = d;
        ce_n = ~sel;
        if (sel) begin
            wr_q.push_back({a, d});
            exp_mem[a] = d;
        end
        cyc(3);
        if (fmt_sep) begin
            wr_rw = 1'b0; cyc(5); wr_rw = 1'b1;
        end else begin
            wr_rw = 1'b0; cyc(1); rd_ds = 1'b1; cyc(5); rd_ds = 1'b0; cyc(1); wr_rw = 1'b1;
        end
        cyc(4);
        ce_n = 1'b1;
        data_in = 8'h00;
        cyc(4);
    endtask

    task automatic bus_read(input logic [3:0] a, input string req);
        addr_phase(a);
        ce_n = 1'b0;
        rd_q.push_back(a);
        cyc(3);
        if (fmt_sep) rd_ds = 1'b0;
        else begin wr_rw = 1'b1; rd_ds = 1'b1; end
        cyc(7);
        chk(data_oe == 1'b1, "R8 oe during read", data_oe, 1);
        chk(data_out == exp_mem[a], req, data_out, exp_mem[a]);
        if (fmt_sep) rd_ds = 1'b1;
        else rd_ds = 1'b0;
        cyc(5);
        chk(data_oe == 1'b0, "R8 oe after read", data_oe, 0);
        ce_n = 1'b1;
        cyc(4);
    endtask

    task automatic do_reset(input bit strap);
        mux_strap_n = strap;
        rst_n = 1'b0;
        cyc(3);
        chk(irq_n == 1'b1 && data_oe == 1'b0 && !wr_pulse && !rd_pulse,
            "R12 reset outputs", {irq_n, data_oe, wr_pulse, rd_pulse}, 4'b1000);
        rst_n = 1'b1;
        mux_m = ~strap;
        cyc(6);
    endtask

    task automatic pulse_done();
        xfer_done = 1'b1; cyc(1); xfer_done = 1'b0; cyc(2);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin regs[i] = 8'h00; exp_mem[i] = 8'h00; end
        do_reset(1'b1);

        // R3 separate strobes, non-multiplexed
        bus_write(4'h3, 8'h5A, 1'b1);
        bus_write(4'h7, 8'hC3, 1'b1);
        bus_write(4'h0, 8'hFF, 1'b1);
        bus_read(4'h3, "R3 read data 3");
        bus_read(4'h7, "R7 read data 7");
        bus_read(4'h0, "R7 read data 0");

        // R1 strap change after reset has no effect
        mux_strap_n = 1'b0;
        bus_write(4'h9, 8'h11, 1'b1);
        bus_read(4'h9, "R1 strap ignored");

        // R4 data strobe with direction line
        rd_ds = 1'b0; fmt_sep = 1'b0; cyc(4);
        bus_write(4'h4, 8'h66, 1'b1);
        bus_read(4'h4, "R4 read data 4");
        bus_read(4'h3, "R4 read data 3");

        // R5 chip enable high: write ignored
        bus_write(4'h4, 8'h99, 1'b0);
        bus_read(4'h4, "R5 ignored write");

        // R9 / R10 interrupt
        irq_en = 1'b1;
        pulse_done();
        chk(irq_n == 1'b0, "R9 irq asserted", irq_n, 0);
        irq_en = 1'b0; cyc(1);
        chk(irq_n == 1'b1, "R9 irq masked", irq_n, 1);
        irq_en = 1'b1; cyc(1);
        chk(irq_n == 1'b0, "R9 irq still pending", irq_n, 0);
        bus_read(4'h5, "R10 non-status read");
        chk(irq_n == 1'b0, "R10 other read keeps irq", irq_n, 0);
        bus_read(4'hE, "R10 status read data");
        chk(irq_n == 1'b1, "R10 irq released", irq_n, 1);

        // R2 multiplexed mode
        rd_ds = 1'b1; fmt_sep = 1'b1; cyc(4);
        do_reset(1'b0);
        bus_write(4'h5, 8'h3C, 1'b1);
        bus_read(4'h5, "R2 mux read 5");
        rd_ds = 1'b0; fmt_sep = 1'b0; cyc(4);
        bus_write(4'h6, 8'h81, 1'b1);
        bus_read(4'h6, "R2 mux read 6");

        // R11 interrupt silent in multiplexed mode
        pulse_done();
        chk(irq_n == 1'b1, "R11 irq quiet in mux", irq_n, 1);

        // R1 strap released after reset: still multiplexed
        mux_strap_n = 1'b1;
        bus_write(4'hB, 8'h42, 1'b1);
        bus_read(4'hB, "R1 mux held");

        cyc(4);
        chk(wr_q.size() == 0, "R6 all writes seen", wr_q.size(), 0);
        chk(rd_q.size() == 0, "R7 all reads seen", rd_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule